// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns the configuration of a DRAM controller's chip-select rows into a page lookup. Software programs eight cumulative boundary bytes, one per row, plus an attribute word that gives each row's device width and a mode word that sets boundary granularity, channel count and whether ECC is on. For any 4 KiB page number placed on the query input, the block answers combinationally. It reports which row holds that page, the page range the row covers, the row's device width and the ECC scheme that protects it.

Configuration is held in registers that are loaded through three simple write ports. A two-bit variant code chooses between the one controller flavour that can run a single channel and every other flavour, which always run dual channel with a coarse boundary unit. Rows whose boundary equals the boundary below them hold no memory, and they are skipped.

Top module: `rowmap_decode`

## Requirements
- R1: After reset every boundary byte, the attribute word and the mode word are zero, so every query misses.
- R2: A boundary, attribute or mode write is applied at the clock edge where its write enable is high, and it changes the lookup result from the next cycle on.
- R3: A boundary unit is 8192 pages (32 MiB) only when the variant code is 1 and mode bits 19:18 are both zero. In every other case it is 16384 pages (64 MiB).
- R4: Row n covers the pages from B(n-1) times unit up to B(n) times unit minus one, with B(-1) taken as 0. On a hit, first_page and last_page give those two ends.
- R5: A row whose boundary equals the boundary of the row below it never hits. When several rows would match, the one with the lowest index is reported.
- R6: A page at or above the range of every populated row gives hit low, with row_idx, row_x4, ecc_mode, first_page and last_page all zero.
- R7: On a hit, row_x4 equals bit 4n+3 of the attribute word for the reported row n. A value of 1 means x4 devices and 0 means x8 devices.
- R8: Dual-channel operation is mode bit 22 when the variant code is 1. It is always on for any other variant code.
- R9: ecc_mode is 0 (off) when mode bits 21:20 are zero. Otherwise it is 2 (x4 symbol correction) when the row is dual channel with x4 devices, and 1 (single-correct double-detect) in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_we | input | 1 | Boundary byte write enable |
| bnd_sel | input | 3 | Row whose boundary byte is written |
| bnd_data | input | 8 | Boundary byte value |
| attr_we | input | 1 | Attribute word write enable |
| attr_data | input | 32 | Attribute word value |
| mode_we | input | 1 | Mode word write enable |
| mode_data | input | 32 | Mode word value |
| variant | input | 2 | Controller variant code (1 = single-channel capable) |
| query_page | input | 22 | 4 KiB page number to look up |
| hit | output | 1 | Page lies in a populated row |
| row_idx | output | 3 | Row holding the page |
| row_x4 | output | 1 | Device width of that row (1 = x4) |
| ecc_mode | output | 2 | ECC scheme: 0 off, 1 SECDED, 2 x4 symbol |
| first_page | output | 22 | First page of the row |
| last_page | output | 22 | Last page of the row |

## Verification
The hardest case to reach is a page that sits exactly on the boundary shared by a populated row and a run of empty rows above it. Only there do the skipping of empty rows and the lowest-index priority decide the answer. Directed layouts with repeated boundary bytes put queries on each row's first page, its last page and the page just past it. Random layouts then draw empty rows with high probability. All of this is repeated under both boundary units and both variant classes.

// File: rtl/rowmap_pkg.sv
`timescale 1ns/1ps
package rowmap_pkg;
  localparam int FINE_SHIFT = 13;   // 32 MiB in 4 KiB pages
  localparam int MODE_DUAL_BIT = 22;
  localparam int MODE_ECC_LO = 20;
  localparam int MODE_GRAN_LO = 18;

  typedef enum logic [1:0] {
    ECC_OFF    = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_X4SYM  = 2'd2
  } ecc_e;

  // Scale a cumulative boundary byte into a page count.
  function automatic logic [31:0] bnd_pages(input logic [7:0] b, input logic coarse);
    logic [31:0] w;
    w = {24'd0, b};
    return coarse ? (w << (FINE_SHIFT + 1)) : (w << FINE_SHIFT);
  endfunction

  function automatic ecc_e ecc_pick(input logic [1:0] ecc_en, input logic dual, input logic x4);
    if (ecc_en == 2'b00) return ECC_OFF;
    if (dual && x4) return ECC_X4SYM;
    return ECC_SECDED;
  endfunction
endpackage

// File: rtl/rowmap_cfg.sv
`timescale 1ns/1ps
module rowmap_cfg #(
  parameter int ROWS   = 8,
  parameter int BND_W  = 8,
  parameter int WORD_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bnd_we,
  input  logic [ROW_W-1:0]            bnd_sel,
  input  logic [BND_W-1:0]            bnd_data,
  input  logic                        attr_we,
  input  logic [WORD_W-1:0]           attr_data,
  input  logic                        mode_we,
  input  logic [WORD_W-1:0]           mode_data,
  output logic [ROWS-1:0][BND_W-1:0]  bnd_q,
  output logic [WORD_W-1:0]           attr_q,
  output logic [WORD_W-1:0]           mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_q  <= '0;
      attr_q <= '0;
      mode_q <= '0;
    end else begin
      if (bnd_we)  bnd_q[bnd_sel] <= bnd_data;
      if (attr_we) attr_q <= attr_data;
      if (mode_we) mode_q <= mode_data;
    end
  end

  a_r2_bnd_write: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_we |=> bnd_q[$past(bnd_sel)] == $past(bnd_data));
  a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q == $past(mode_data));
endmodule

// File: rtl/rowmap_row.sv
`timescale 1ns/1ps
module rowmap_row #(
  parameter int BND_W  = 8,
  parameter int PAGE_W = 22
) (
  input  logic [BND_W-1:0]  cur_b,
  input  logic [BND_W-1:0]  prev_b,
  input  logic              coarse,
  input  logic [PAGE_W-1:0] page,
  output logic              populated,
  output logic              match,
  output logic [PAGE_W-1:0] lo_pg,
  output logic [PAGE_W-1:0] hi_pg
);
  import rowmap_pkg::*;
  logic [31:0] lo_w, hi_w;

  always_comb begin
    lo_w = bnd_pages(8'(prev_b), coarse);
    hi_w = bnd_pages(8'(cur_b), coarse);
    populated = (cur_b != prev_b);
    match = populated && ({10'd0, page} >= lo_w) && ({10'd0, page} < hi_w);
    lo_pg = PAGE_W'(lo_w);
    hi_pg = PAGE_W'(hi_w - 32'd1);
  end
endmodule

// File: rtl/rowmap_select.sv
`timescale 1ns/1ps
module rowmap_select #(
  parameter int ROWS   = 8,
  parameter int PAGE_W = 22,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]              match,
  input  logic [ROWS-1:0][PAGE_W-1:0]  lo_v,
  input  logic [ROWS-1:0][PAGE_W-1:0]  hi_v,
  output logic                         hit,
  output logic [ROW_W-1:0]             idx,
  output logic [PAGE_W-1:0]            first_pg,
  output logic [PAGE_W-1:0]            last_pg
);
  // Scan from the top so the lowest matching row overwrites last.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    first_pg = '0;
    last_pg = '0;
    for (int n = ROWS - 1; n >= 0; n--) begin
      if (match[n]) begin
        hit = 1'b1;
        idx = ROW_W'(n);
        first_pg = lo_v[n];
        last_pg = hi_v[n];
      end
    end
  end
endmodule

// File: rtl/rowmap_decode.sv
`timescale 1ns/1ps
module rowmap_decode #(
  parameter int ROWS        = 8,
  parameter int BND_W       = 8,
  parameter int PAGE_W      = 22,
  parameter int WORD_W      = 32,
  parameter logic [1:0] SC_VARIANT = 2'd1,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_we,
  input  logic [ROW_W-1:0]  bnd_sel,
  input  logic [BND_W-1:0]  bnd_data,
  input  logic              attr_we,
  input  logic [WORD_W-1:0] attr_data,
  input  logic              mode_we,
  input  logic [WORD_W-1:0] mode_data,
  input  logic [1:0]        variant,
  input  logic [PAGE_W-1:0] query_page,
  output logic              hit,
  output logic [ROW_W-1:0]  row_idx,
  output logic              row_x4,
  output logic [1:0]        ecc_mode,
  output logic [PAGE_W-1:0] first_page,
  output logic [PAGE_W-1:0] last_page
);
  import rowmap_pkg::*;

  logic [ROWS-1:0][BND_W-1:0]  bnd_q;
  logic [WORD_W-1:0]           attr_q, mode_q;
  logic [ROWS-1:0]             row_pop, row_match, x4_vec;
  logic [ROWS-1:0][PAGE_W-1:0] lo_v, hi_v;
  logic                        sc_part, dual_on, coarse;
  logic                        sel_hit;
  logic [ROW_W-1:0]            sel_idx;
  logic [PAGE_W-1:0]           sel_first, sel_last;

  rowmap_cfg #(.ROWS(ROWS), .BND_W(BND_W), .WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .bnd_we(bnd_we), .bnd_sel(bnd_sel), .bnd_data(bnd_data),
    .attr_we(attr_we), .attr_data(attr_data),
    .mode_we(mode_we), .mode_data(mode_data),
    .bnd_q(bnd_q), .attr_q(attr_q), .mode_q(mode_q)
  );

  assign sc_part = (variant == SC_VARIANT);
  assign dual_on = sc_part ? mode_q[MODE_DUAL_BIT] : 1'b1;
  assign coarse  = sc_part ? (mode_q[MODE_GRAN_LO+1:MODE_GRAN_LO] != 2'b00) : 1'b1;

  for (genvar n = 0; n < ROWS; n++) begin : g_row
    logic [BND_W-1:0] prev_b;
    if (n == 0) begin : g_first
      assign prev_b = '0;
    end else begin : g_next
      assign prev_b = bnd_q[n-1];
    end
    assign x4_vec[n] = attr_q[4*n+3];
    rowmap_row #(.BND_W(BND_W), .PAGE_W(PAGE_W)) u_row (
      .cur_b(bnd_q[n]), .prev_b(prev_b), .coarse(coarse), .page(query_page),
      .populated(row_pop[n]), .match(row_match[n]),
      .lo_pg(lo_v[n]), .hi_pg(hi_v[n])
    );
  end

  rowmap_select #(.ROWS(ROWS), .PAGE_W(PAGE_W)) u_sel (
    .match(row_match), .lo_v(lo_v), .hi_v(hi_v),
    .hit(sel_hit), .idx(sel_idx), .first_pg(sel_first), .last_pg(sel_last)
  );

  assign hit        = sel_hit;
  assign row_idx    = sel_idx;
  assign first_page = sel_first;
  assign last_page  = sel_last;
  assign row_x4     = sel_hit & x4_vec[sel_idx];
  assign ecc_mode   = sel_hit ? ecc_pick(mode_q[MODE_ECC_LO+1:MODE_ECC_LO], dual_on, x4_vec[sel_idx])
                              : ECC_OFF;

  a_r4_page_inside: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (query_page >= first_page) && (query_page <= last_page));
  a_r5_populated_only: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> row_pop[row_idx]);
  a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (row_idx == '0) && !row_x4 && (ecc_mode == ECC_OFF)
             && (first_page == '0) && (last_page == '0));
  a_r9_ecc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_ECC_LO+1:MODE_ECC_LO] == 2'b00) |-> ecc_mode == ECC_OFF);
  a_r9_x8_no_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !row_x4) |-> ecc_mode != ECC_X4SYM);
endmodule

// File: tb/sim_rowmap_decode.sv
`timescale 1ns/1ps
module sim_rowmap_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_we = 1'b0;
  logic [2:0]  bnd_sel = '0;
  logic [7:0]  bnd_data = '0;
  logic        attr_we = 1'b0;
  logic [31:0] attr_data = '0;
  logic        mode_we = 1'b0;
  logic [31:0] mode_data = '0;
  logic [1:0]  variant = '0;
  logic [21:0] query_page = '0;
  logic        hit, row_x4;
  logic [2:0]  row_idx;
  logic [1:0]  ecc_mode;
  logic [21:0] first_page, last_page;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int          m_bnd [8];
  logic [31:0] m_attr = '0;
  logic [31:0] m_mode = '0;

  always #2.5 clk = ~clk;

  rowmap_decode u0 (
    .clk(clk), .rst_n(rst_n), .bnd_we(bnd_we), .bnd_sel(bnd_sel), .bnd_data(bnd_data),
    .attr_we(attr_we), .attr_data(attr_data), .mode_we(mode_we), .mode_data(mode_data),
    .variant(variant), .query_page(query_page), .hit(hit), .row_idx(row_idx),
    .row_x4(row_x4), .ecc_mode(ecc_mode), .first_page(first_page), .last_page(last_page)
  );

  function automatic int unit_pages();
    if (variant == 2'd1 && m_mode[19:18] == 2'b00) return 8192;
    return 16384;
  endfunction

  task automatic put_bnd(input int n, input int v);
    @(negedge clk);
    bnd_we = 1'b1; bnd_sel = 3'(n); bnd_data = 8'(v);
    m_bnd[n] = v;
    @(negedge clk);
    bnd_we = 1'b0;
  endtask

  task automatic put_all(input int b0, input int b1, input int b2, input int b3,
                         input int b4, input int b5, input int b6, input int b7);
    put_bnd(0, b0); put_bnd(1, b1); put_bnd(2, b2); put_bnd(3, b3);
    put_bnd(4, b4); put_bnd(5, b5); put_bnd(6, b6); put_bnd(7, b7);
  endtask

  task automatic put_attr(input logic [31:0] v);
    @(negedge clk);
    attr_we = 1'b1; attr_data = v; m_attr = v;
    @(negedge clk);
    attr_we = 1'b0;
  endtask

  task automatic put_mode(input logic [31:0] v);
    @(negedge clk);
    mode_we = 1'b1; mode_data = v; m_mode = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Expected result: walk rows keeping the running lower bound.
  task automatic ask(input int page, input string tag);
    int u, lo, hi, e_idx, e_first, e_last;
    bit e_hit, e_x4, dual;
    logic [1:0] e_ecc;
    u = unit_pages();
    e_hit = 0; e_idx = 0; e_first = 0; e_last = 0; e_x4 = 0; e_ecc = 2'd0;
    lo = 0;
    for (int n = 0; n < 8; n++) begin
      hi = m_bnd[n] * u;
      if (!e_hit && hi != lo && page >= lo && page < hi) begin
        e_hit = 1; e_idx = n; e_first = lo; e_last = hi - 1;
        e_x4 = m_attr[4*n+3];
      end
      lo = hi;
    end
    dual = (variant != 2'd1) || m_mode[22];
    if (e_hit && m_mode[21:20] != 2'b00) e_ecc = (dual && e_x4) ? 2'd2 : 2'd1;
    @(negedge clk);
    query_page = 22'(page);
    #1;
    total++;
    if (hit !== e_hit || row_idx !== 3'(e_idx) || row_x4 !== e_x4 || ecc_mode !== e_ecc
        || first_page !== 22'(e_first) || last_page !== 22'(e_last)) begin
      bad++;
      $display("FAIL %s page=%0d got hit=%0b row=%0d x4=%0b ecc=%0d first=%0d last=%0d exp hit=%0b row=%0d x4=%0b ecc=%0d first=%0d last=%0d",
               tag, page, hit, row_idx, row_x4, ecc_mode, first_page, last_page,
               e_hit, e_idx, e_x4, e_ecc, e_first, e_last);
    end
  endtask

  task automatic edges(input string tag);
    int u;
    u = unit_pages();
    ask(0, tag);
    for (int n = 0; n < 8; n++) begin
      ask(m_bnd[n] * u, tag);
      if (m_bnd[n] > 0) ask(m_bnd[n] * u - 1, tag);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) m_bnd[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state misses everywhere
    ask(0, "R1");
    ask(123456, "R1");

    // R2, R4, R5: layout with empty rows between populated ones
    variant = 2'd0;
    put_mode(32'h0010_0000);
    put_attr(32'h0000_0080);
    put_all(2, 2, 5, 5, 5, 9, 9, 9);
    ask(32767, "R4");
    ask(32768, "R5");
    ask(81919, "R4");
    ask(81920, "R5");
    ask(147455, "R4");
    ask(147456, "R6");
    edges("R5");
    put_bnd(1, 3);
    ask(32768, "R2");

    // R7: width bit per row
    put_attr(32'h0000_0008);
    ask(0, "R7");
    ask(40000, "R7");

    // R3, R8: single-channel-capable variant, fine unit, single channel
    variant = 2'd1;
    put_attr(32'h8888_8888);
    put_mode(32'h0010_0000);
    edges("R3");
    ask(20000, "R8");
    put_mode(32'h0050_0000);
    ask(20000, "R8");
    put_mode(32'h0054_0000);
    edges("R3");

    // R9: ECC off with bits 21:20 zero, also other variant ignores bit 22 and granularity
    put_mode(32'h0040_0000);
    ask(100, "R9");
    variant = 2'd2;
    put_mode(32'h0030_0000);
    ask(100, "R9");
    edges("R8");

    // Random layouts
    for (int k = 0; k < 12; k++) begin
      int acc;
      acc = 0;
      variant = 2'($urandom_range(0, 3));
      put_mode($urandom() & 32'h007C_0000);
      put_attr($urandom());
      for (int n = 0; n < 8; n++) begin
        if ($urandom_range(0, 2) != 0) acc = acc + $urandom_range(1, 30);
        if (acc > 255) acc = 255;
        put_bnd(n, acc);
      end
      edges("R4");
      for (int q = 0; q < 20; q++) ask($urandom_range(0, acc * 16384 + 20000), "R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule